// File: doc/BRIEF.md
# Guarded Nonvolatile Write Sequencer

This block sits between a CPU register bus and a small on-chip nonvolatile data array and decides when a write into that array may happen. Software loads a target address and a data byte into two plain registers. It then unlocks the write with two control-register stores on consecutive cycles: the first sets the enable bit and the second sets the start bit. Any other pattern of stores is refused. Once started, the sequencer copies the address and data, counts edges of a slow, unrelated timer tick, commits the byte to the array, clears the start bit and raises a completion request flag.

The control register can only be reached while the CPU's memory-pointer high byte selects a chosen sector (sector 1 by default), which gives a second guard against stray stores. An interrupt register holds a global enable, a local enable and the request flag. An acknowledge input clears the flag and drops the global enable, as a vectoring CPU does on entry. A sleep request is answered only after any write in progress has finished.

Top module: `nvwr_top`

## Requirements
- R1: After reset the write-enable bit, the start/busy bit, the request flag and both interrupt enables are 0. `busy` and `intReq` are low.
- R2: The control register (select 2) is written and read only when `sectorSel` equals CTRL_SECTOR (1). From any other sector, stores to it are ignored and it reads as 0.
- R3: A write starts only when a control store with bit1 (start) = 1 and bit0 (enable) = 1 follows, on the very next clock, a control store with bit0 = 1 and bit1 = 0. A start store one or more idle cycles later does nothing.
- R4: A start store whose unlock step was never made starts nothing. This includes a single store with enable and start both set, and a start store while enable is clear.
- R5: While a write runs, control bit1 and `busy` read 1. They clear after WRITE_TICKS rising edges of `slowTick`, which is passed through a two-flop synchronizer. At that moment the array location holds the data captured at start.
- R6: On completion, interrupt-register bit2 (request flag) is set. `intReq` is high only when the flag, bit1 (local enable) and bit0 (global enable) are all 1.
- R7: A pulse on `intAck` clears the request flag and the global enable.
- R8: While a write runs, stores to the address register (select 0) and data register (select 1) are ignored, and new start sequences neither restart nor extend the write.
- R9: `sleepOk` follows `sleepReq` only while no write is running. During a write it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register store strobe |
| busSel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 interrupt |
| busWdata | input | DATA_W | Store data |
| busRdata | output | DATA_W | Read data of the selected register |
| sectorSel | input | SECTOR_W | Memory-pointer high byte (sector select) |
| slowTick | input | 1 | Asynchronous write-duration timer tick |
| intAck | input | 1 | Interrupt acknowledge pulse |
| intReq | output | 1 | Gated write-complete interrupt request |
| busy | output | 1 | Write in progress |
| sleepReq | input | 1 | Request to enter low-power mode |
| sleepOk | output | 1 | Low-power entry granted |
| nvRdAddr | input | ADDR_W | Array inspection address |
| nvRdData | output | DATA_W | Array contents at nvRdAddr |

## Verification
The bench tries the unlock sequence in the forms that must fail: the start store one cycle late, enable and start in a single store, start with enable clear, and a correct sequence sent from sector 0. A sequencer that armed on a stale enable, or ignored the sector, would start a write and `busy` would rise. A start sequence is repeated halfway through a write. A design that restarted its timer would then stay busy after the final tick. Address and data stores made during a write are checked by reading the registers back and the array contents afterwards, which catches a design that captures late. Sleep gating and the flag-versus-enable combinations of the interrupt are checked around completion and acknowledge.

// File: rtl/nvwr_pkg.sv
package nvwr_pkg;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_INT  = 2'd3;

  localparam int BIT_EN     = 0;
  localparam int BIT_START  = 1;
  localparam int BIT_GLOBAL = 0;
  localparam int BIT_LOCAL  = 1;
  localparam int BIT_FLAG   = 2;

  typedef struct packed {
    logic capture;
    logic commit;
  } nvStrobe_t;
endpackage

// File: rtl/nvwr_sync.sv
module nvwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut
);
  logic [STAGES-1:0] chainQ;
  logic lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= '0;
      lastQ  <= 1'b0;
    end else begin
      chainQ <= {chainQ[STAGES-2:0], asyncIn};
      lastQ  <= chainQ[STAGES-1];
    end
  end

  assign riseOut = chainQ[STAGES-1] & ~lastQ;
endmodule

// File: rtl/nvwr_ctrl.sv
module nvwr_ctrl
  import nvwr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SECTOR_W    = 8,
  parameter int CTRL_SECTOR = 1,
  parameter int WRITE_TICKS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [1:0]          busSel,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [SECTOR_W-1:0] sectorSel,
  input  logic                tickRise,
  input  logic                intAck,
  output nvStrobe_t           stb,
  output logic                wrEnQ,
  output logic                busyQ,
  output logic                flagQ,
  output logic                localEnQ,
  output logic                globalEnQ,
  output logic                ctrlVisible,
  output logic                intReq
);
  localparam int CNT_W = $clog2(WRITE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic armedQ;
  logic ctrlHit, intHit, startReq, doneNow;

  assign ctrlVisible = (sectorSel == SECTOR_W'(CTRL_SECTOR));
  assign ctrlHit  = busWe && (busSel == SEL_CTRL) && ctrlVisible;
  assign intHit   = busWe && (busSel == SEL_INT);
  assign startReq = ctrlHit && busWdata[BIT_START] && busWdata[BIT_EN] && armedQ && !busyQ;
  assign doneNow  = busyQ && tickRise && (tickCnt == LAST_CNT);

  assign stb.capture = startReq;
  assign stb.commit  = doneNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      wrEnQ  <= 1'b0;
      busyQ  <= 1'b0;
      tickCnt <= '0;
    end else begin
      armedQ <= ctrlHit && busWdata[BIT_EN] && !busWdata[BIT_START];
      if (ctrlHit) wrEnQ <= busWdata[BIT_EN];
      if (startReq) begin
        busyQ   <= 1'b1;
        tickCnt <= '0;
      end else if (doneNow) begin
        busyQ   <= 1'b0;
        tickCnt <= '0;
      end else if (busyQ && tickRise) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ     <= 1'b0;
      localEnQ  <= 1'b0;
      globalEnQ <= 1'b0;
    end else begin
      if (doneNow) flagQ <= 1'b1;
      else if (intAck) flagQ <= 1'b0;
      else if (intHit) flagQ <= flagQ & busWdata[BIT_FLAG];
      if (intAck) globalEnQ <= 1'b0;
      else if (intHit) globalEnQ <= busWdata[BIT_GLOBAL];
      if (intHit) localEnQ <= busWdata[BIT_LOCAL];
    end
  end

  assign intReq = flagQ & localEnQ & globalEnQ;

  // R3
  arm_before_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(armedQ));
  // R4
  no_blind_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(wrEnQ) && wrEnQ);
  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> flagQ);
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck && !doneNow |=> !flagQ && !globalEnQ);
  // R6
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> localEnQ && globalEnQ);
endmodule

// File: rtl/nvwr_dp.sv
module nvwr_dp
  import nvwr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [1:0]        busSel,
  input  logic [DATA_W-1:0] busWdata,
  input  nvStrobe_t         stb,
  input  logic              busyQ,
  input  logic              wrEnQ,
  input  logic              flagQ,
  input  logic              localEnQ,
  input  logic              globalEnQ,
  input  logic              ctrlVisible,
  input  logic [ADDR_W-1:0] nvRdAddr,
  output logic [DATA_W-1:0] nvRdData,
  output logic [DATA_W-1:0] busRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ, shAddrQ;
  logic [DATA_W-1:0] dataQ, shDataQ;
  logic [DATA_W-1:0] nvArray [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      shAddrQ <= '0;
      shDataQ <= '0;
    end else begin
      if (busWe && !busyQ && busSel == SEL_ADDR) addrQ <= busWdata[ADDR_W-1:0];
      if (busWe && !busyQ && busSel == SEL_DATA) dataQ <= busWdata;
      if (stb.capture) begin
        shAddrQ <= addrQ;
        shDataQ <= dataQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.commit) nvArray[shAddrQ] <= shDataQ;
  end

  assign nvRdData = nvArray[nvRdAddr];

  always_comb begin
    busRdata = '0;
    unique case (busSel)
      SEL_ADDR: busRdata[ADDR_W-1:0] = addrQ;
      SEL_DATA: busRdata = dataQ;
      SEL_CTRL: if (ctrlVisible) begin
        busRdata[BIT_EN]    = wrEnQ;
        busRdata[BIT_START] = busyQ;
      end
      SEL_INT: begin
        busRdata[BIT_GLOBAL] = globalEnQ;
        busRdata[BIT_LOCAL]  = localEnQ;
        busRdata[BIT_FLAG]   = flagQ;
      end
      default: busRdata = '0;
    endcase
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && $past(busyQ) |-> $stable(shAddrQ) && $stable(shDataQ));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busyQ) && busyQ |-> $stable(addrQ));
endmodule

// File: rtl/nvwr_top.sv
module nvwr_top
  import nvwr_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SECTOR_W    = 8,
  parameter int CTRL_SECTOR = 1,
  parameter int WRITE_TICKS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [1:0]          busSel,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [SECTOR_W-1:0] sectorSel,
  input  logic                slowTick,
  input  logic                intAck,
  output logic                intReq,
  output logic                busy,
  input  logic                sleepReq,
  output logic                sleepOk,
  input  logic [ADDR_W-1:0]   nvRdAddr,
  output logic [DATA_W-1:0]   nvRdData
);
  nvStrobe_t stb;
  logic tickRise, wrEnQ, busyQ, flagQ, localEnQ, globalEnQ, ctrlVisible;

  nvwr_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(slowTick), .riseOut(tickRise));

  nvwr_ctrl #(.DATA_W(DATA_W), .SECTOR_W(SECTOR_W), .CTRL_SECTOR(CTRL_SECTOR),
              .WRITE_TICKS(WRITE_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busSel(busSel), .busWdata(busWdata),
    .sectorSel(sectorSel), .tickRise(tickRise), .intAck(intAck), .stb(stb),
    .wrEnQ(wrEnQ), .busyQ(busyQ), .flagQ(flagQ), .localEnQ(localEnQ),
    .globalEnQ(globalEnQ), .ctrlVisible(ctrlVisible), .intReq(intReq));

  nvwr_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busSel(busSel), .busWdata(busWdata),
    .stb(stb), .busyQ(busyQ), .wrEnQ(wrEnQ), .flagQ(flagQ), .localEnQ(localEnQ),
    .globalEnQ(globalEnQ), .ctrlVisible(ctrlVisible), .nvRdAddr(nvRdAddr),
    .nvRdData(nvRdData), .busRdata(busRdata));

  assign busy    = busyQ;
  assign sleepOk = sleepReq & ~busyQ;

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sleepOk);
endmodule

// File: tb/sim_nvwr_top.sv
`timescale 1ns/1ps
module sim_nvwr_top;
  localparam int TICKS = 4;
  logic clk = 0, rstN = 0, busWe = 0, slowTick = 0, intAck = 0, sleepReq = 0;
  logic [1:0] busSel = 0;
  logic [7:0] busWdata = 0, busRdata, sectorSel = 0, nvRdData;
  logic [3:0] nvRdAddr = 0;
  logic intReq, busy, sleepOk;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nvwr_top #(.WRITE_TICKS(TICKS)) u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busSel(busSel), .busWdata(busWdata),
    .busRdata(busRdata), .sectorSel(sectorSel), .slowTick(slowTick), .intAck(intAck),
    .intReq(intReq), .busy(busy), .sleepReq(sleepReq), .sleepOk(sleepOk),
    .nvRdAddr(nvRdAddr), .nvRdData(nvRdData));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d, logic [7:0] sec);
    @(negedge clk);
    busWe = 1; busSel = sel; busWdata = d; sectorSel = sec;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic rd(logic [1:0] sel, logic [7:0] sec, output logic [7:0] v);
    @(negedge clk);
    busWe = 0; busSel = sel; sectorSel = sec;
    #1 v = busRdata;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slowTick = 1;
      repeat (3) @(negedge clk);
      slowTick = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic unlock(logic [7:0] sec);
    wr(2'd2, 8'h01, sec);
    wr(2'd2, 8'h03, sec);
    idle();
  endtask

  task automatic testReset();
    logic [7:0] v;
    rd(2'd2, 8'd1, v); check("R1 ctrl", v, 8'h00);
    rd(2'd3, 8'd0, v); check("R1 int", v, 8'h00);
    check("R1 busy", {7'd0, busy}, 8'h00);
    check("R1 intReq", {7'd0, intReq}, 8'h00);
  endtask

  task automatic testRefused();
    logic [7:0] v;
    wr(2'd0, 8'h05, 8'd0); wr(2'd1, 8'hA5, 8'd0); idle();
    unlock(8'd0);
    rd(2'd2, 8'd1, v); check("R2 wrong sector store ignored", v, 8'h00);
    rd(2'd2, 8'd0, v); check("R2 wrong sector reads 0", v, 8'h00);
    wr(2'd2, 8'h01, 8'd1); idle(); wr(2'd2, 8'h03, 8'd1); idle();
    check("R3 late start", {7'd0, busy}, 8'h00);
    wr(2'd2, 8'h03, 8'd1); idle();
    check("R4 en+start together", {7'd0, busy}, 8'h00);
    wr(2'd2, 8'h00, 8'd1); wr(2'd2, 8'h02, 8'd1); idle();
    check("R4 start with en clear", {7'd0, busy}, 8'h00);
  endtask

  task automatic testWrite();
    logic [7:0] v;
    wr(2'd3, 8'h03, 8'd0); idle();
    unlock(8'd1);
    rd(2'd2, 8'd1, v); check("R5 start bit reads busy", v[1], 1'b1);
    sleepReq = 1;
    #1 check("R9 sleep held", {7'd0, sleepOk}, 8'h00);
    wr(2'd0, 8'h09, 8'd0); wr(2'd1, 8'h3C, 8'd0); idle();
    rd(2'd0, 8'd0, v); check("R8 addr ignored", v, 8'h05);
    rd(2'd1, 8'd0, v); check("R8 data ignored", v, 8'hA5);
    pulses(2);
    unlock(8'd1);
    pulses(TICKS - 3);
    check("R5 still busy before last tick", {7'd0, busy}, 8'h01);
    check("R6 no req yet", {7'd0, intReq}, 8'h00);
    pulses(1);
    check("R8 no restart, done", {7'd0, busy}, 8'h00);
    rd(2'd2, 8'd1, v); check("R5 start bit cleared", v[1], 1'b0);
    nvRdAddr = 4'd5;
    #1 check("R5 array content", nvRdData, 8'hA5);
    check("R9 sleep granted", {7'd0, sleepOk}, 8'h01);
    sleepReq = 0;
    rd(2'd3, 8'd0, v); check("R6 flag set", v, 8'h07);
    check("R6 intReq", {7'd0, intReq}, 8'h01);
    wr(2'd3, 8'h05, 8'd0); idle();
    #1 check("R6 local gate", {7'd0, intReq}, 8'h00);
    wr(2'd3, 8'h07, 8'd0); idle();
    @(negedge clk); intAck = 1; @(negedge clk); intAck = 0;
    rd(2'd3, 8'd0, v); check("R7 ack clears", v, 8'h02);
    check("R7 intReq low", {7'd0, intReq}, 8'h00);
  endtask

  task automatic testSecond();
    wr(2'd0, 8'h0C, 8'd0); wr(2'd1, 8'h5A, 8'd0); idle();
    unlock(8'd1);
    check("R3 immediate start", {7'd0, busy}, 8'h01);
    pulses(TICKS);
    nvRdAddr = 4'd12;
    #1 check("R5 second array content", nvRdData, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testRefused();
    testWrite();
    testSecond();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule